// File: doc/BRIEF.md
# Chained Device Selection and Read Gating

This block decides whether one member of a chain of identical devices answers register and data traffic. Each member holds a page address, which is its identity in the chain, and a target select value, which names the member that the host wants to address. The member is selected when the two values are equal. A select value of all ones addresses every member at once. That broadcast form allows writes to all members but stops every member from driving the read bus.

Page addresses are loaded one member at a time. A load token is held by exactly one member. Only that member takes a page-address write. An advance command makes the holder give up the token and pulse an output that hands the token to the next member downstream.

Next-free-address reads have a chain mode with its own rule. When chain mode is on, the member that drives is the one whose upstream neighbours are all full and which still has room itself. In this mode the select value plays no part.

Top module: `chain_select`

## Requirements
- R1: Hard reset (rst_n low, asynchronous) sets the page address and the select value to 0x0000, sets the load token to the FIRST_IN_CHAIN parameter (default 1), and sets tok_out to 0.
- R2: When pa_wr is high and the token is held, the page address loads wdata on the clock edge. A write of 0xFFFF is rejected and the old page address is kept.
- R3: A page-address write made while the token is not held has no effect.
- R4: When ds_wr is high, the select value loads wdata, and any value is accepted, 0xFFFF included.
- R5: selected is high when the select value equals the page address, or when the select value is 0xFFFF.
- R6: While the select value is 0xFFFF, rd_oe stays low for every read except a chain-mode next-free read.
- R7: Apart from chain mode, rd_oe = rd_req & selected & not broadcast & (rd_sel != 3). The read codes are rd_sel 0 = page address, giving {16'h0000, page}; 1 = select value, giving {status_hi, select}; 2 = next free, giving {status_hi, nf_addr}; 3 = nothing. rd_data is zero whenever rd_oe is low. All of these outputs are combinational.
- R8: When rd_req is high, rd_sel is 2 and chain_en is high, rd_oe = !up_fill_n & own_fill_n, whatever the select value. Both fill flags are active low.
- R9: An advance with the token held clears the token, and tok_out is high for exactly the next cycle. An advance without the token leaves tok_out low.
- R10: tok_in high sets the token on the clock edge. An advance in the same cycle wins and the token is cleared.
- R11: Soft reset leaves the page address and the select value unchanged. It returns the token to FIRST_IN_CHAIN, clears tok_out, and overrides an advance or tok_in in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, asynchronous, active low |
| soft_rst | input | 1 | Synchronous soft reset |
| pa_wr | input | 1 | Page address write strobe |
| ds_wr | input | 1 | Select value write strobe |
| wdata | input | 16 | Write data |
| rd_req | input | 1 | Read request |
| rd_sel | input | 2 | Read source code |
| chain_en | input | 1 | Chain mode for next-free reads |
| up_fill_n | input | 1 | Low when every upstream member is full |
| own_fill_n | input | 1 | Low when this member is full |
| status_hi | input | 16 | Upper status half for read-back |
| nf_addr | input | 16 | Next free address from the array |
| adv | input | 1 | Advance command, passes the token on |
| tok_in | input | 1 | Token handed over from upstream |
| selected | output | 1 | Member is addressed |
| rd_oe | output | 1 | Member drives the read bus |
| rd_data | output | 32 | Read-back data |
| tok_out | output | 1 | One-cycle token pass to downstream |

## Verification
The bench writes 0xFFFF to the page address and then reads the address back. A design that accepts that write would make the page address equal to the broadcast code. It steps the token away and then tries a page-address write, which must not land, and it gives an advance together with tok_in, and a soft reset together with an advance, to catch a wrong priority order. In broadcast it checks that ordinary reads are silent while chain-mode next-free reads still follow only the fill flags; a design that gated the chain read on selection would go quiet there. Soft reset is given between a load and a read-back, so a design that cleared the registers on soft reset returns zero.

// File: rtl/chain_sel_pkg.sv
package chain_sel_pkg;

  typedef enum logic [1:0] {
    RSEL_PAGE = 2'd0,
    RSEL_SEL  = 2'd1,
    RSEL_FREE = 2'd2,
    RSEL_NONE = 2'd3
  } rsel_e;

endpackage

// File: rtl/chain_sel_regs.sv
module chain_sel_regs #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pa_wr,
  input  logic         ds_wr,
  input  logic         tok_held,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] pa_q,
  output logic [W-1:0] ds_q
);

  localparam logic [W-1:0] BCAST = {W{1'b1}};

  logic         pa_en;
  logic         ds_en;
  logic [W-1:0] pa_d;
  logic [W-1:0] ds_d;

  // Soft reset is not an input here: both registers survive it.
  always_comb begin
    pa_en = pa_wr & tok_held & (wdata != BCAST);
    ds_en = ds_wr;
    pa_d  = wdata;
    ds_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q <= '0;
    end else if (pa_en) begin
      pa_q <= pa_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ds_q <= '0;
    end else if (ds_en) begin
      ds_q <= ds_d;
    end
  end

endmodule

// File: rtl/chain_sel_token.sv
module chain_sel_token #(
  parameter bit FIRST_IN_CHAIN = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic adv,
  input  logic tok_in,
  output logic tok_q,
  output logic tok_out
);

  logic tok_d;
  logic pass_d;

  // Priority: soft reset, then advance, then incoming token.
  always_comb begin
    tok_d  = tok_q;
    pass_d = 1'b0;
    if (soft_rst) begin
      tok_d = FIRST_IN_CHAIN;
    end else if (adv) begin
      tok_d  = 1'b0;
      pass_d = tok_q;
    end else if (tok_in) begin
      tok_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok_q   <= FIRST_IN_CHAIN;
      tok_out <= 1'b0;
    end else begin
      tok_q   <= tok_d;
      tok_out <= pass_d;
    end
  end

endmodule

// File: rtl/chain_sel_rdmux.sv
module chain_sel_rdmux
  import chain_sel_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0]   pa_q,
  input  logic [W-1:0]   ds_q,
  input  logic           rd_req,
  input  logic [1:0]     rd_sel,
  input  logic           chain_en,
  input  logic           up_fill_n,
  input  logic           own_fill_n,
  input  logic [W-1:0]   status_hi,
  input  logic [W-1:0]   nf_addr,
  output logic           selected,
  output logic           rd_oe,
  output logic [2*W-1:0] rd_data
);

  localparam logic [W-1:0] BCAST = {W{1'b1}};

  rsel_e    src;
  logic     bcast;
  logic     chain_rd;
  logic     plain_oe;

  always_comb begin
    src      = rsel_e'(rd_sel);
    bcast    = (ds_q == BCAST);
    selected = (ds_q == pa_q) | bcast;
    chain_rd = rd_req & (src == RSEL_FREE) & chain_en;
    plain_oe = rd_req & (src != RSEL_NONE) & selected & ~bcast;
    rd_oe    = chain_rd ? (~up_fill_n & own_fill_n) : plain_oe;
    rd_data  = '0;
    if (rd_oe) begin
      unique case (src)
        RSEL_PAGE: rd_data = {{W{1'b0}}, pa_q};
        RSEL_SEL:  rd_data = {status_hi, ds_q};
        RSEL_FREE: rd_data = {status_hi, nf_addr};
        default:   rd_data = '0;
      endcase
    end
  end

endmodule

// File: rtl/chain_select.sv
module chain_select #(
  parameter int W              = 16,
  parameter bit FIRST_IN_CHAIN = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           soft_rst,
  input  logic           pa_wr,
  input  logic           ds_wr,
  input  logic [W-1:0]   wdata,
  input  logic           rd_req,
  input  logic [1:0]     rd_sel,
  input  logic           chain_en,
  input  logic           up_fill_n,
  input  logic           own_fill_n,
  input  logic [W-1:0]   status_hi,
  input  logic [W-1:0]   nf_addr,
  input  logic           adv,
  input  logic           tok_in,
  output logic           selected,
  output logic           rd_oe,
  output logic [2*W-1:0] rd_data,
  output logic           tok_out
);

  logic [W-1:0] pa_q;
  logic [W-1:0] ds_q;
  logic         tok_q;

  chain_sel_token #(.FIRST_IN_CHAIN(FIRST_IN_CHAIN)) u_token (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .adv      (adv),
    .tok_in   (tok_in),
    .tok_q    (tok_q),
    .tok_out  (tok_out)
  );

  chain_sel_regs #(.W(W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .pa_wr    (pa_wr),
    .ds_wr    (ds_wr),
    .tok_held (tok_q),
    .wdata    (wdata),
    .pa_q     (pa_q),
    .ds_q     (ds_q)
  );

  chain_sel_rdmux #(.W(W)) u_rdmux (
    .pa_q       (pa_q),
    .ds_q       (ds_q),
    .rd_req     (rd_req),
    .rd_sel     (rd_sel),
    .chain_en   (chain_en),
    .up_fill_n  (up_fill_n),
    .own_fill_n (own_fill_n),
    .status_hi  (status_hi),
    .nf_addr    (nf_addr),
    .selected   (selected),
    .rd_oe      (rd_oe),
    .rd_data    (rd_data)
  );

endmodule

// File: rtl/chain_select_chk.sv
module chain_select_chk #(
  parameter int W              = 16,
  parameter bit FIRST_IN_CHAIN = 1'b1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           soft_rst,
  input logic           pa_wr,
  input logic           ds_wr,
  input logic [W-1:0]   wdata,
  input logic           rd_req,
  input logic [1:0]     rd_sel,
  input logic           chain_en,
  input logic           up_fill_n,
  input logic           own_fill_n,
  input logic           adv,
  input logic           rd_oe,
  input logic [2*W-1:0] rd_data,
  input logic           tok_out,
  input logic [W-1:0]   pa_q,
  input logic [W-1:0]   ds_q,
  input logic           tok_q
);

  localparam logic [W-1:0] ONES = {W{1'b1}};

  a_r2_reject_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_wr && wdata == ONES) |=> $stable(pa_q));

  a_r3_no_token_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_wr && !tok_q) |=> $stable(pa_q));

  a_r11_soft_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && !pa_wr && !ds_wr) |=> ($stable(pa_q) && $stable(ds_q)
                                        && tok_q == FIRST_IN_CHAIN && !tok_out));

  a_r6_bcast_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_q == ONES && !(rd_req && rd_sel == 2'd2 && chain_en)) |-> !rd_oe);

  a_r8_chain_free: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_sel == 2'd2 && chain_en) |-> (rd_oe == (!up_fill_n && own_fill_n)));

  a_r9_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && tok_q && !soft_rst) |=> (tok_out && !tok_q));

  a_r9_pulse_once: assert property (@(posedge clk) disable iff (!rst_n)
    tok_out |=> !tok_out);

  a_r7_quiet_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_oe |-> (rd_data == '0));

endmodule

bind chain_select chain_select_chk #(.W(W), .FIRST_IN_CHAIN(FIRST_IN_CHAIN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .soft_rst   (soft_rst),
  .pa_wr      (pa_wr),
  .ds_wr      (ds_wr),
  .wdata      (wdata),
  .rd_req     (rd_req),
  .rd_sel     (rd_sel),
  .chain_en   (chain_en),
  .up_fill_n  (up_fill_n),
  .own_fill_n (own_fill_n),
  .adv        (adv),
  .rd_oe      (rd_oe),
  .rd_data    (rd_data),
  .tok_out    (tok_out),
  .pa_q       (pa_q),
  .ds_q       (ds_q),
  .tok_q      (tok_q)
);

// File: tb/test_chain_select.sv
module test_chain_select;

  logic        clk;
  logic        rst_n;
  logic        soft_rst;
  logic        pa_wr;
  logic        ds_wr;
  logic [15:0] wdata;
  logic        rd_req;
  logic [1:0]  rd_sel;
  logic        chain_en;
  logic        up_fill_n;
  logic        own_fill_n;
  logic [15:0] status_hi;
  logic [15:0] nf_addr;
  logic        adv;
  logic        tok_in;
  logic        selected;
  logic        rd_oe;
  logic [31:0] rd_data;
  logic        tok_out;

  chain_select i_chain_select (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .pa_wr(pa_wr), .ds_wr(ds_wr),
    .wdata(wdata), .rd_req(rd_req), .rd_sel(rd_sel), .chain_en(chain_en),
    .up_fill_n(up_fill_n), .own_fill_n(own_fill_n), .status_hi(status_hi),
    .nf_addr(nf_addr), .adv(adv), .tok_in(tok_in), .selected(selected),
    .rd_oe(rd_oe), .rd_data(rd_data), .tok_out(tok_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk;
  int n_fail;
  bit done;

  // Reference state, kept from the requirements only
  logic [15:0] m_pa;
  logic [15:0] m_ds;
  logic        m_tok;
  logic        m_tout;

  function automatic logic f_sel(logic [15:0] pa, logic [15:0] ds);
    return (ds == pa) || (ds == 16'hFFFF);   // R5
  endfunction

  function automatic logic f_oe(logic [15:0] pa, logic [15:0] ds, logic rq, logic [1:0] rs,
                                logic ce, logic uf, logic of);
    if (rq && rs == 2'd2 && ce) return !uf && of;   // R8
    return rq && rs != 2'd3 && f_sel(pa, ds) && ds != 16'hFFFF;  // R6, R7
  endfunction

  function automatic logic [31:0] f_data(logic oe, logic [1:0] rs, logic [15:0] pa,
                                         logic [15:0] ds, logic [15:0] st, logic [15:0] nf);
    if (!oe) return 32'h0;
    case (rs)
      2'd0:    return {16'h0000, pa};
      2'd1:    return {st, ds};
      2'd2:    return {st, nf};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(logic pw, logic dw, logic [15:0] wd, logic rq, logic [1:0] rs,
                      logic ce, logic uf, logic of, logic ad, logic ti, logic sr,
                      string tag);
    logic       e_oe;
    string      t_oe;
    @(negedge clk);
    pa_wr = pw; ds_wr = dw; wdata = wd; rd_req = rq; rd_sel = rs; chain_en = ce;
    up_fill_n = uf; own_fill_n = of; adv = ad; tok_in = ti; soft_rst = sr;
    status_hi = 16'($urandom); nf_addr = 16'($urandom);
    #1;
    e_oe = f_oe(m_pa, m_ds, rq, rs, ce, uf, of);
    if (rq && rs == 2'd2 && ce) t_oe = "R8";
    else if (m_ds == 16'hFFFF) t_oe = "R6";
    else t_oe = "R7";
    check(tag, "R5 selected", 32'(selected), 32'(f_sel(m_pa, m_ds)));
    check(tag, {t_oe, " rd_oe"}, 32'(rd_oe), 32'(e_oe));
    check(tag, "R7 rd_data", rd_data, f_data(e_oe, rs, m_pa, m_ds, status_hi, nf_addr));
    check(tag, "R9 tok_out", 32'(tok_out), 32'(m_tout));
    // next state of the reference, for the coming edge
    if (pw && m_tok && wd != 16'hFFFF) m_pa = wd;
    if (dw) m_ds = wd;
    m_tout = !sr && ad && m_tok;
    if (sr) m_tok = 1'b1;
    else if (ad) m_tok = 1'b0;
    else if (ti) m_tok = 1'b1;
  endtask

  task automatic idle_read(logic [1:0] rs, string tag);
    step(0, 0, 16'h0, 1, rs, 0, 1, 1, 0, 0, 0, tag);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 0;
    void'($urandom(32'd1357));
    rst_n = 0; soft_rst = 0; pa_wr = 0; ds_wr = 0; wdata = 0; rd_req = 0; rd_sel = 0;
    chain_en = 0; up_fill_n = 1; own_fill_n = 1; status_hi = 0; nf_addr = 0;
    adv = 0; tok_in = 0;
    m_pa = 0; m_ds = 0; m_tok = 1; m_tout = 0;
    #1;
    check("R1", "reset selected", 32'(selected), 32'd1);
    check("R1", "reset tok_out", 32'(tok_out), 32'd0);
    #20;
    @(negedge clk) rst_n = 1;

    idle_read(2'd0, "R1");                                // page reads as zero
    step(1, 1, 16'h1234, 0, 0, 0, 1, 1, 0, 0, 0, "R2");  // load page and select
    idle_read(2'd0, "R2");
    step(1, 0, 16'hFFFF, 0, 0, 0, 1, 1, 0, 0, 0, "R2");  // rejected write
    idle_read(2'd0, "R2");
    idle_read(2'd1, "R4");
    step(0, 1, 16'hFFFF, 0, 0, 0, 1, 1, 0, 0, 0, "R4");  // broadcast
    idle_read(2'd1, "R6");
    idle_read(2'd2, "R6");
    step(0, 0, 16'h0, 1, 2, 1, 0, 1, 0, 0, 0, "R8");
    step(0, 0, 16'h0, 1, 2, 1, 0, 0, 0, 0, 0, "R8");
    step(0, 0, 16'h0, 1, 2, 1, 1, 1, 0, 0, 0, "R8");
    step(0, 0, 16'h0, 0, 0, 0, 1, 1, 1, 0, 0, "R9");     // advance with token
    step(1, 0, 16'h5555, 0, 0, 0, 1, 1, 1, 0, 0, "R9");  // pulse seen, no token
    step(0, 1, 16'h1234, 0, 0, 0, 1, 1, 0, 0, 0, "R3");
    idle_read(2'd0, "R3");
    step(0, 0, 16'h0, 0, 0, 0, 1, 1, 1, 1, 0, "R10");    // advance beats tok_in
    step(1, 0, 16'h0777, 0, 0, 0, 1, 1, 0, 1, 0, "R10"); // still no token
    step(1, 1, 16'h0777, 0, 0, 0, 1, 1, 0, 0, 0, "R10"); // now loads
    idle_read(2'd0, "R10");
    step(0, 0, 16'h0, 0, 0, 0, 1, 1, 1, 0, 1, "R11");    // soft beats advance
    idle_read(2'd0, "R11");
    idle_read(2'd1, "R11");

    for (int i = 0; i < 3000; i++) begin
      logic [15:0] wd;
      int          pick;
      pick = int'($urandom_range(0, 9));
      if (pick < 2) wd = 16'hFFFF;
      else if (pick < 5) wd = m_pa;
      else wd = 16'($urandom_range(0, 7));
      step(($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0), wd,
           1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           ($urandom_range(0, 7) == 0), ($urandom_range(0, 3) == 0),
           ($urandom_range(0, 15) == 0), "rand");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule